// File: doc/BRIEF.md
# Four-Sequencer Sample Capture FIFO with Timer Trigger Select

This block is the result-capture stage of a converter with four sample sequencers. Each sequencer has an enable bit and a 4-bit trigger-source code. When the external timer trigger pulses, every sequencer that is enabled and has the timer code selected stores one sample in its own 16-entry FIFO and raises its raw interrupt bit. The conversion itself is not modelled. A linear-congruential generator produces the sample values instead, and each value is 0x200 plus three bits of the generator state.

Software reaches the block through a simple register port. Each read completes in the cycle it is issued, and a read of a sequencer's data register pops one entry from that FIFO. Each FIFO exposes its pointers and its empty and full flags in a packed status word. Pushes into a full FIFO and pops from an empty FIFO are recorded in per-sequencer sticky flags. Each interrupt output is the raw bit gated by a mask bit.

Top module: `adc_capture`

## Requirements
- R1: On a cycle with `timer_trig` high, sequencer n pushes a sample only when enable register (0x00) bit n is 1 and its source field, bits 4n+3:4n of the source register (0x10), equals 5. No other code causes a push.
- R2: Sequencers that fire in the same cycle are served in ascending index order. For each one, a 32-bit state (reset value 0) first becomes state*314159+1, and the sample is then 0x200 plus bits 18:16 of the new state. A push attempt into a full FIFO still advances the state.
- R3: A push into a full FIFO is discarded and sets overflow bit n (register 0x14). Otherwise the sample is stored at the write pointer, the write pointer advances modulo 16, empty clears, and full sets when the write pointer reaches the read pointer.
- R4: Reading the data register (0x48 + 0x20n) returns the entry at the read pointer. If the FIFO is empty, nothing moves and underflow bit n (register 0x18) sets. Otherwise the read pointer advances modulo 16, full clears, and empty sets when the read pointer reaches the write pointer.
- R5: The status word (0x4C + 0x20n) carries the read pointer in bits 3:0, the write pointer in bits 7:4, empty in bit 8 and full in bit 12. All other bits read 0.
- R6: Every push attempt sets raw interrupt bit n (register 0x04). Writing a 1 to bit n of 0x0C clears it, and a set in the same cycle wins. `irq[n]` equals raw bit n AND mask bit n (register 0x08).
- R7: Overflow and underflow bits hold until a 1 is written to that bit of their own register. A new event in the same cycle wins.
- R8: A trigger push and a data-register pop on the same FIFO in one cycle are both applied, judged against the flags held before that cycle. When both succeed, the empty and full flags keep their values.
- R9: Synchronous reset leaves every status word at 0x100 and clears enable, source, mask, raw, overflow and underflow. It also clears each sequencer's input-select (0x40 + 0x20n) and control (0x44 + 0x20n) words.
- R10: The input-select and control words of each sequencer, and the enable, source and mask registers, read back the value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; pops when it addresses a data register |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle the read is issued |
| timer_trig | input | 1 | Timer trigger, one pulse per cycle high |
| irq | output | 4 | Masked per-sequencer interrupts |

## Verification
The checker assumes that a pop reaches a FIFO only through a read strobe that addresses its data register, and that a push reaches it only through a trigger pulse that meets the enable and source conditions. It does not constrain how often either happens. The stimulus holds each strobe for exactly one cycle and drops it just after the edge. It never mixes a write and a read in one cycle, so each pop and each clear appears as a single event. The bench fills every FIFO slot before its first underflow read, so the entry returned from an empty FIFO has a known value.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
    localparam int NSEQ       = 4;
    localparam int PTR_W      = 4;
    localparam int FIFO_DEPTH = 1 << PTR_W;
    localparam int SAMPLE_W   = 10;
    localparam int SRC_W      = 4;
    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int SIDX_W     = $clog2(NSEQ);
    localparam int SOFS_W     = 5;

    localparam logic [SRC_W-1:0]    SRC_TIMER   = 4'd5;
    localparam logic [31:0]         LCG_MUL     = 32'd314159;
    localparam logic [31:0]         LCG_INC     = 32'd1;
    localparam logic [SAMPLE_W-1:0] SAMPLE_BASE = 10'h200;

    // global registers
    localparam logic [ADDR_W-1:0] A_ENABLE = 12'h000;
    localparam logic [ADDR_W-1:0] A_RAW    = 12'h004;
    localparam logic [ADDR_W-1:0] A_MASK   = 12'h008;
    localparam logic [ADDR_W-1:0] A_ICLR   = 12'h00C;
    localparam logic [ADDR_W-1:0] A_SRC    = 12'h010;
    localparam logic [ADDR_W-1:0] A_OVF    = 12'h014;
    localparam logic [ADDR_W-1:0] A_UNF    = 12'h018;
    // per-sequencer window
    localparam logic [ADDR_W-1:0] SEQ_BASE   = 12'h040;
    localparam int                SEQ_STRIDE = 1 << SOFS_W;
    localparam logic [SOFS_W-1:0] S_INSEL = 5'h00;
    localparam logic [SOFS_W-1:0] S_CTRL  = 5'h04;
    localparam logic [SOFS_W-1:0] S_DATA  = 5'h08;
    localparam logic [SOFS_W-1:0] S_STAT  = 5'h0C;

    typedef struct packed {
        logic             full;
        logic             empty;
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
    } fifo_stat_t;

    function automatic logic [DATA_W-1:0] stat_word(fifo_stat_t s);
        logic [DATA_W-1:0] w;
        w       = '0;
        w[3:0]  = s.rd;
        w[7:4]  = s.wr;
        w[8]    = s.empty;
        w[12]   = s.full;
        return w;
    endfunction

    function automatic logic [31:0] lcg_next(logic [31:0] x);
        return x * LCG_MUL + LCG_INC;
    endfunction

    function automatic logic [SAMPLE_W-1:0] sample_of(logic [31:0] x);
        return SAMPLE_BASE + {{(SAMPLE_W-3){1'b0}}, x[18:16]};
    endfunction
endpackage

// File: rtl/adc_cap_fifo.sv
module adc_cap_fifo
    import adc_cap_pkg::*;
#(
    parameter int DW = SAMPLE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output fifo_stat_t    stat,
    output logic          ovf_evt,
    output logic          unf_evt
);
    logic [DW-1:0]    mem [FIFO_DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q, rd_n, wr_n;
    logic             empty_q, full_q;
    logic             push_ok, pop_ok;

    assign push_ok = push & ~full_q;
    assign pop_ok  = pop & ~empty_q;
    assign wr_n    = wr_q + PTR_W'(push_ok);
    assign rd_n    = rd_q + PTR_W'(pop_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q    <= '0;
            wr_q    <= '0;
            empty_q <= 1'b1;
            full_q  <= 1'b0;
        end else begin
            rd_q <= rd_n;
            wr_q <= wr_n;
            unique case ({push_ok, pop_ok})
                2'b10: begin
                    empty_q <= 1'b0;
                    full_q  <= (wr_n == rd_q);
                end
                2'b01: begin
                    full_q  <= 1'b0;
                    empty_q <= (rd_n == wr_q);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_q] <= din;
    end

    assign dout    = mem[rd_q];
    assign ovf_evt = push & full_q;
    assign unf_evt = pop & empty_q;
    assign stat    = '{full: full_q, empty: empty_q, wr: wr_q, rd: rd_q};
endmodule

// File: rtl/adc_cap_noise.sv
module adc_cap_noise
    import adc_cap_pkg::*;
#(
    parameter int N = NSEQ
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N-1:0]                fire,
    output logic [N-1:0][SAMPLE_W-1:0]  sample
);
    logic [31:0]      state_q;
    logic [N:0][31:0] chain;
    logic [N-1:0][31:0] step;

    assign chain[0] = state_q;

    for (genvar i = 0; i < N; i++) begin : g_step
        assign step[i]      = lcg_next(chain[i]);
        assign chain[i+1]   = fire[i] ? step[i] : chain[i];
        assign sample[i]    = sample_of(step[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= chain[N];
    end
endmodule

// File: rtl/adc_capture.sv
module adc_capture
    import adc_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              timer_trig,
    output logic [NSEQ-1:0]   irq
);
    localparam int          REL_W   = SOFS_W + SIDX_W;
    localparam logic [ADDR_W-1:0] SEQ_END = SEQ_BASE + ADDR_W'(SEQ_STRIDE * NSEQ);

    logic [NSEQ-1:0]        en_q, mask_q, raw_q, ovf_q, unf_q;
    logic [NSEQ*SRC_W-1:0]  src_q;
    logic [DATA_W-1:0]      insel_q [NSEQ];
    logic [DATA_W-1:0]      ctrl_q  [NSEQ];

    logic                   in_seq;
    logic [REL_W-1:0]       seq_rel;
    logic [SIDX_W-1:0]      seq_idx;
    logic [SOFS_W-1:0]      seq_off;

    logic [NSEQ-1:0]        fire, pop, ovf_evt, unf_evt;
    logic [NSEQ-1:0]        iclr, ovf_clr, unf_clr;
    fifo_stat_t [NSEQ-1:0]  stat;
    logic [NSEQ-1:0][SAMPLE_W-1:0] sample, fifo_dout;

    assign in_seq  = (bus_addr >= SEQ_BASE) && (bus_addr < SEQ_END);
    assign seq_rel = bus_addr[REL_W-1:0] - SEQ_BASE[REL_W-1:0];
    assign seq_idx = seq_rel[SOFS_W +: SIDX_W];
    assign seq_off = seq_rel[SOFS_W-1:0];

    assign iclr    = (bus_wr && bus_addr == A_ICLR) ? bus_wdata[NSEQ-1:0] : '0;
    assign ovf_clr = (bus_wr && bus_addr == A_OVF)  ? bus_wdata[NSEQ-1:0] : '0;
    assign unf_clr = (bus_wr && bus_addr == A_UNF)  ? bus_wdata[NSEQ-1:0] : '0;

    adc_cap_noise #(.N(NSEQ)) u_noise (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .sample (sample)
    );

    for (genvar n = 0; n < NSEQ; n++) begin : g_seq
        assign fire[n] = timer_trig && en_q[n] && (src_q[n*SRC_W +: SRC_W] == SRC_TIMER);
        assign pop[n]  = bus_rd && in_seq && (seq_idx == SIDX_W'(n)) && (seq_off == S_DATA);

        adc_cap_fifo #(.DW(SAMPLE_W)) u_fifo (
            .clk     (clk),
            .rst     (rst),
            .push    (fire[n]),
            .pop     (pop[n]),
            .din     (sample[n]),
            .dout    (fifo_dout[n]),
            .stat    (stat[n]),
            .ovf_evt (ovf_evt[n]),
            .unf_evt (unf_evt[n])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                insel_q[n] <= '0;
                ctrl_q[n]  <= '0;
            end else if (bus_wr && in_seq && seq_idx == SIDX_W'(n)) begin
                if (seq_off == S_INSEL) insel_q[n] <= bus_wdata;
                if (seq_off == S_CTRL)  ctrl_q[n]  <= bus_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            mask_q <= '0;
            src_q  <= '0;
            raw_q  <= '0;
            ovf_q  <= '0;
            unf_q  <= '0;
        end else begin
            if (bus_wr && bus_addr == A_ENABLE) en_q   <= bus_wdata[NSEQ-1:0];
            if (bus_wr && bus_addr == A_MASK)   mask_q <= bus_wdata[NSEQ-1:0];
            if (bus_wr && bus_addr == A_SRC)    src_q  <= bus_wdata[NSEQ*SRC_W-1:0];
            raw_q <= (raw_q & ~iclr)    | fire;
            ovf_q <= (ovf_q & ~ovf_clr) | ovf_evt;
            unf_q <= (unf_q & ~unf_clr) | unf_evt;
        end
    end

    assign irq = raw_q & mask_q;

    always_comb begin
        bus_rdata = '0;
        if (in_seq) begin
            unique case (seq_off)
                S_INSEL: bus_rdata = insel_q[seq_idx];
                S_CTRL:  bus_rdata = ctrl_q[seq_idx];
                S_DATA:  bus_rdata = DATA_W'(fifo_dout[seq_idx]);
                S_STAT:  bus_rdata = stat_word(stat[seq_idx]);
                default: bus_rdata = '0;
            endcase
        end else begin
            unique case (bus_addr)
                A_ENABLE: bus_rdata = DATA_W'(en_q);
                A_RAW:    bus_rdata = DATA_W'(raw_q);
                A_MASK:   bus_rdata = DATA_W'(mask_q);
                A_SRC:    bus_rdata = DATA_W'(src_q);
                A_OVF:    bus_rdata = DATA_W'(ovf_q);
                A_UNF:    bus_rdata = DATA_W'(unf_q);
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/adc_capture_chk.sv
module adc_capture_chk
    import adc_cap_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [NSEQ-1:0]       fire,
    input logic [NSEQ-1:0]       pop,
    input fifo_stat_t [NSEQ-1:0] stat,
    input logic [NSEQ-1:0]       raw_q,
    input logic [NSEQ-1:0]       ovf_q,
    input logic [NSEQ-1:0]       unf_q,
    input logic [NSEQ-1:0]       ovf_clr,
    input logic [NSEQ-1:0]       unf_clr,
    input logic [NSEQ-1:0]       irq
);
    for (genvar i = 0; i < NSEQ; i++) begin : g_chk
        p_flags_excl_r5: assert property (@(posedge clk) disable iff (rst)
            !(stat[i].full && stat[i].empty));

        p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
            (stat[i].full && fire[i] && !pop[i]) |=> ($stable(stat[i]) && ovf_q[i]));

        p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
            (stat[i].empty && pop[i] && !fire[i]) |=> ($stable(stat[i]) && unf_q[i]));

        p_fire_sets_raw_r6: assert property (@(posedge clk) disable iff (rst)
            fire[i] |=> raw_q[i]);

        p_irq_needs_raw_r6: assert property (@(posedge clk) disable iff (rst)
            irq[i] |-> raw_q[i]);

        p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
            (ovf_q[i] && !ovf_clr[i]) |=> ovf_q[i]);

        p_unf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
            (unf_q[i] && !unf_clr[i]) |=> unf_q[i]);

        p_both_keep_r8: assert property (@(posedge clk) disable iff (rst)
            (fire[i] && pop[i] && !stat[i].full && !stat[i].empty)
            |=> ($stable(stat[i].full) && $stable(stat[i].empty)));
    end
endmodule

bind adc_capture adc_capture_chk u_chk (.*);

// File: tb/sim_adc_capture.sv
module sim_adc_capture;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, timer_trig = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int checks = 0, failures = 0;
    bit done = 0;

    // reference model
    int          m_rd [4], m_wr [4];
    bit          m_emp [4], m_full [4];
    logic [9:0]  m_mem [4][16];
    bit   [3:0]  m_raw, m_ovf, m_unf, m_en, m_mask;
    logic [15:0] m_src;
    logic [31:0] m_ns;

    adc_capture u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .timer_trig(timer_trig), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int n = 0; n < 4; n++) begin
            m_rd[n] = 0; m_wr[n] = 0; m_emp[n] = 1; m_full[n] = 0;
            for (int k = 0; k < 16; k++) m_mem[n][k] = '0;
        end
        m_raw = 0; m_ovf = 0; m_unf = 0; m_en = 0; m_mask = 0; m_src = 0; m_ns = 0;
    endtask

    task automatic model_step(input bit wr, input bit rd, input logic [11:0] a,
                              input logic [31:0] wd, input bit trig);
        bit push [4]; bit pp [4]; bit e0, f0;
        logic [9:0] smp;
        for (int n = 0; n < 4; n++) begin
            push[n] = trig && m_en[n] && (m_src[n*4 +: 4] == 4'd5);
            pp[n]   = rd && (a == 12'h048 + 12'(n*32));
        end
        if (wr && a == 12'h00C) m_raw &= ~wd[3:0];
        if (wr && a == 12'h014) m_ovf &= ~wd[3:0];
        if (wr && a == 12'h018) m_unf &= ~wd[3:0];
        for (int n = 0; n < 4; n++) begin
            e0 = m_emp[n]; f0 = m_full[n];
            if (push[n]) begin
                m_ns = m_ns * 32'd314159 + 32'd1;
                smp  = 10'h200 + {7'b0, m_ns[18:16]};
                m_raw[n] = 1;
                if (f0) m_ovf[n] = 1;
                else begin
                    m_mem[n][m_wr[n]] = smp;
                    m_wr[n] = (m_wr[n] + 1) % 16;
                end
            end
            if (pp[n]) begin
                if (e0) m_unf[n] = 1;
                else m_rd[n] = (m_rd[n] + 1) % 16;
            end
            if (push[n] && !f0 && !(pp[n] && !e0)) begin
                m_emp[n] = 0; m_full[n] = (m_wr[n] == m_rd[n]);
            end else if (pp[n] && !e0 && !(push[n] && !f0)) begin
                m_full[n] = 0; m_emp[n] = (m_rd[n] == m_wr[n]);
            end
        end
        if (wr && a == 12'h000) m_en = wd[3:0];
        if (wr && a == 12'h008) m_mask = wd[3:0];
        if (wr && a == 12'h010) m_src = wd[15:0];
    endtask

    task automatic cycle(input bit wr, input bit rd, input logic [11:0] a,
                         input logic [31:0] wd, input bit trig, output logic [31:0] rv);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd; timer_trig = trig;
        #1 rv = bus_rdata;
        @(posedge clk);
        #1;
        bus_wr = 0; bus_rd = 0; timer_trig = 0;
        model_step(wr, rd, a, wd, trig);
    endtask

    task automatic wreg(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] rv;
        cycle(1, 0, a, d, 0, rv);
    endtask

    task automatic rreg(input logic [11:0] a, output logic [31:0] d);
        cycle(0, 1, a, '0, 0, d);
    endtask

    task automatic trig();
        logic [31:0] rv;
        cycle(0, 0, 12'h000, '0, 1, rv);
    endtask

    // pop sequencer n, optionally with a trigger in the same cycle (R4, R8)
    task automatic pop(input int n, input bit t);
        logic [31:0] rv, exp;
        exp = {22'b0, m_mem[n][m_rd[n]]};
        cycle(0, 1, 12'h048 + 12'(n*32), '0, t, rv);
        chk(t ? "R8 pop data" : "R4 pop data", rv, exp);
    endtask

    task automatic check_all(input string req);
        logic [31:0] rv, exp;
        for (int n = 0; n < 4; n++) begin
            rreg(12'h04C + 12'(n*32), rv);
            exp = {19'b0, m_full[n], 3'b0, m_emp[n], 4'(m_wr[n]), 4'(m_rd[n])};
            chk({req, " R5 status"}, rv, exp);
        end
        rreg(12'h004, rv); chk({req, " R6 raw"}, rv, {28'b0, m_raw});
        rreg(12'h014, rv); chk({req, " R3 ovf"}, rv, {28'b0, m_ovf});
        rreg(12'h018, rv); chk({req, " R4 unf"}, rv, {28'b0, m_unf});
        #1 chk({req, " R6 irq"}, {28'b0, irq}, {28'b0, m_raw & m_mask});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rv;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R9: reset state
        check_all("R9");
        rreg(12'h000, rv); chk("R9 enable", rv, 0);
        rreg(12'h010, rv); chk("R9 source", rv, 0);
        rreg(12'h008, rv); chk("R9 mask", rv, 0);
        for (int n = 0; n < 4; n++) begin
            rreg(12'h040 + 12'(n*32), rv); chk("R9 insel", rv, 0);
            rreg(12'h044 + 12'(n*32), rv); chk("R9 ctrl", rv, 0);
        end

        // R10: readback
        for (int n = 0; n < 4; n++) begin
            wreg(12'h040 + 12'(n*32), 32'hA5000000 + 32'(n));
            wreg(12'h044 + 12'(n*32), 32'h00C0FFEE + 32'(n << 8));
        end
        for (int n = 0; n < 4; n++) begin
            rreg(12'h040 + 12'(n*32), rv); chk("R10 insel", rv, 32'hA5000000 + 32'(n));
            rreg(12'h044 + 12'(n*32), rv); chk("R10 ctrl", rv, 32'h00C0FFEE + 32'(n << 8));
        end
        wreg(12'h008, 32'h5);
        rreg(12'h008, rv); chk("R10 mask", rv, 32'h5);

        // R1: sweep all source codes with all sequencers enabled
        wreg(12'h000, 32'hF);
        rreg(12'h000, rv); chk("R10 enable", rv, 32'hF);
        for (int c = 0; c < 16; c++) begin
            wreg(12'h010, 32'(c * 16'h1111));
            rreg(12'h010, rv); chk("R10 source", rv, 32'(c * 16'h1111));
            trig();
            check_all("R1 code");
        end
        // R1: sweep enable patterns with the timer code everywhere
        wreg(12'h010, 32'h5555);
        for (int e = 0; e < 16; e++) begin
            wreg(12'h000, 32'(e));
            trig();
            check_all("R1 enable");
        end
        // mixed codes: only sequencers 1 and 3 select the timer
        wreg(12'h000, 32'hF);
        wreg(12'h010, 32'h5453);
        trig();
        check_all("R1 mixed");

        // R3: fill to full and beyond
        wreg(12'h010, 32'h5555);
        for (int k = 0; k < 10; k++) begin
            trig();
            check_all("R3 fill");
        end

        // R7: clear overflow with W1C, partial then all
        wreg(12'h014, 32'h3);
        check_all("R7 ovf clr");
        wreg(12'h014, 32'hF);
        check_all("R7 ovf clr all");

        // R8: pop while full, trigger in same cycle
        pop(0, 1);
        check_all("R8 full");

        // R4/R2: drain every FIFO and read one past empty
        for (int n = 0; n < 4; n++) begin
            for (int k = 0; k < 17; k++) pop(n, 0);
        end
        check_all("R4 drain");

        // R7: underflow clear
        wreg(12'h018, 32'h6);
        check_all("R7 unf clr");
        wreg(12'h018, 32'hF);
        check_all("R7 unf clr all");

        // R8: empty + trigger, then one entry + trigger
        wreg(12'h000, 32'h1);
        pop(0, 1);
        check_all("R8 empty");
        pop(0, 1);
        check_all("R8 one entry");
        pop(0, 0);
        check_all("R8 drained");

        // R6: mask sweep and interrupt clear
        for (int m = 0; m < 16; m++) begin
            wreg(12'h008, 32'(m));
            check_all("R6 mask");
        end
        wreg(12'h00C, 32'h5);
        check_all("R6 iclr");
        wreg(12'h000, 32'hF);
        // clear and set together: set wins
        cycle(1, 0, 12'h00C, 32'hF, 1, rv);
        check_all("R6 clr vs set");
        wreg(12'h00C, 32'hF);
        check_all("R6 iclr all");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule